// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular reorder buffer for an out-of-order core. Each accepted instruction takes the slot at the tail and gets that slot number as its result tag. Execution units later report results against a tag, in any order. The buffer retires only the oldest slot, once its result is present. Retirement sends a register write, a memory store or nothing, depending on the instruction kind stored in the slot.

The issue stage can look up a register number. The buffer answers with the youngest pending producer of that register. If that producer has finished, the answer carries its value; if not, it carries its tag so the consumer can wait for the completion broadcast.

A branch that completes with its misprediction flag set flushes every slot when it reaches the head. The next instruction then allocates the slot after the flushed branch.

Top module: `retire_queue`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, and `cm_reg_we`, `cm_mem_we` and `cm_flush` are all 0.
- R2: `iss_accept` is 1 exactly when `iss_valid` and `rs_free` are both 1, the buffer is not full and `cm_flush` is 0. `iss_tag` is the allocation slot, and successive accepted issues get slot numbers that increase by one modulo DEPTH.
- R3: After DEPTH accepted issues with no retirement, `full` is 1 and further issue requests are refused. `empty` is 1 exactly when no slot is occupied.
- R4: A completion with `cmp_valid` = 1 stores `cmp_value` and `cmp_mispredict` into slot `cmp_tag` at the clock edge. Completions may arrive in any order.
- R5: A slot is retired only when it is the oldest occupied slot and its result has been stored. At most one slot retires per cycle, so retirement follows issue order.
- R6: Kind encoding is 0 for a register write, 1 for a store and 2 for a branch. Retiring kind 0 drives `cm_reg_we` = 1, and retiring kind 1 drives `cm_mem_we` = 1. In both cases `cm_dest` and `cm_value` carry the slot's destination and result.
- R7: Retiring a kind 2 slot drives no write. If that slot's result carried `cmp_mispredict` = 1, `cm_flush` is 1 for that cycle. From the next cycle the buffer is empty, the completion presented in the flush cycle is dropped, and the next allocation takes the slot after the flushed branch.
- R8: The lookup on `lk_reg` reports `lk_hit` = 1 with `lk_tag` set to the youngest occupied kind 0 slot whose destination equals `lk_reg`. Slots of kind 1 and kind 2 never match.
- R9: When a lookup hits, `lk_ready` shows whether that slot's result is stored, and `lk_value` then equals it. A result becomes visible to lookup in the cycle after its completion.
- R10: A slot that has retired or been flushed is no longer reported by the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| rs_free | input | 1 | A reservation station is free for the request |
| iss_kind | input | 2 | Instruction kind (0 register, 1 store, 2 branch) |
| iss_dest | input | RW | Destination register, or store target |
| iss_accept | output | 1 | Issue taken this cycle |
| iss_tag | output | AW | Slot allocated to the issue |
| cmp_valid | input | 1 | Completion write |
| cmp_tag | input | AW | Slot being completed |
| cmp_value | input | DW | Result value |
| cmp_mispredict | input | 1 | Branch result was mispredicted |
| cm_reg_we | output | 1 | Retire a register write |
| cm_mem_we | output | 1 | Retire a store |
| cm_flush | output | 1 | Retiring mispredicted branch, flush all |
| cm_dest | output | RW | Destination of the retiring slot |
| cm_value | output | DW | Result of the retiring slot |
| lk_reg | input | RW | Register to look up |
| lk_hit | output | 1 | A pending producer exists |
| lk_ready | output | 1 | Producer result is present |
| lk_tag | output | AW | Producer slot |
| lk_value | output | DW | Producer result |
| full | output | 1 | No free slot |
| empty | output | 1 | No occupied slot |

## Verification
The assertions assume that a completion names a slot that is occupied and has not yet completed. They also assume it never names the slot allocated in the same cycle. The bench keeps this contract by choosing every completion tag from its own model of occupied, unfinished slots. Directed phases fill the buffer to full, drain it with out-of-order completions and force a mispredicted branch flush. A long random phase then mixes issue, completion, lookup and flush, with lookups limited to a small register range so that they hit often.

// File: rtl/retire_queue.sv
module retire_queue #(
  parameter int DEPTH = 16,
  parameter int RW = 5,
  parameter int DW = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic          rs_free,
  input  logic [1:0]    iss_kind,
  input  logic [RW-1:0] iss_dest,
  output logic          iss_accept,
  output logic [AW-1:0] iss_tag,
  input  logic          cmp_valid,
  input  logic [AW-1:0] cmp_tag,
  input  logic [DW-1:0] cmp_value,
  input  logic          cmp_mispredict,
  output logic          cm_reg_we,
  output logic          cm_mem_we,
  output logic          cm_flush,
  output logic [RW-1:0] cm_dest,
  output logic [DW-1:0] cm_value,
  input  logic [RW-1:0] lk_reg,
  output logic          lk_hit,
  output logic          lk_ready,
  output logic [AW-1:0] lk_tag,
  output logic [DW-1:0] lk_value,
  output logic          full,
  output logic          empty
);
  localparam logic [1:0] K_REG = 2'd0, K_STORE = 2'd1, K_BRANCH = 2'd2;

  logic [AW:0]    head_q, tail_q, count;
  logic [1:0]     kind_q  [DEPTH];
  logic [RW-1:0]  dest_q  [DEPTH];
  logic [DW-1:0]  value_q [DEPTH];
  logic [DEPTH-1:0] done_q, mis_q;
  logic [AW-1:0]  hidx, tidx, scan_idx;
  logic           retire;

  assign hidx  = head_q[AW-1:0];
  assign tidx  = tail_q[AW-1:0];
  assign count = tail_q - head_q;
  assign empty = (head_q == tail_q);
  assign full  = (head_q[AW] != tail_q[AW]) && (hidx == tidx);

  assign retire    = !empty && done_q[hidx];
  assign cm_reg_we = retire && kind_q[hidx] == K_REG;
  assign cm_mem_we = retire && kind_q[hidx] == K_STORE;
  assign cm_flush  = retire && kind_q[hidx] == K_BRANCH && mis_q[hidx];
  assign cm_dest   = dest_q[hidx];
  assign cm_value  = value_q[hidx];

  assign iss_accept = iss_valid && rs_free && !full && !cm_flush;
  assign iss_tag    = tidx;

  always_comb begin
    lk_hit = 1'b0;
    lk_tag = '0;
    scan_idx = '0;
    for (int o = 0; o < DEPTH; o++) begin
      scan_idx = hidx + AW'(o);
      if ((AW+1)'(o) < count && kind_q[scan_idx] == K_REG && dest_q[scan_idx] == lk_reg) begin
        lk_hit = 1'b1;
        lk_tag = scan_idx;
      end
    end
  end
  assign lk_ready = lk_hit && done_q[lk_tag];
  assign lk_value = value_q[lk_tag];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      done_q <= '0;
      mis_q  <= '0;
    end else if (cm_flush) begin
      head_q <= head_q + 1'b1;
      tail_q <= head_q + 1'b1;
    end else begin
      if (retire) head_q <= head_q + 1'b1;
      if (iss_accept) begin
        tail_q <= tail_q + 1'b1;
        done_q[tidx] <= 1'b0;
        mis_q[tidx]  <= 1'b0;
      end
      if (cmp_valid) begin
        done_q[cmp_tag] <= 1'b1;
        mis_q[cmp_tag]  <= cmp_mispredict;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (iss_accept) begin
      kind_q[tidx] <= iss_kind;
      dest_q[tidx] <= iss_dest;
    end
    if (cmp_valid && !cm_flush) value_q[cmp_tag] <= cmp_value;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    cm_flush |=> empty);
  a_r5_one_step_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !cm_flush) |=> head_q == $past(head_q) + 1'b1);
  a_r2_issue_occupies: assert property (@(posedge clk) disable iff (!rst_n)
    iss_accept |=> !empty);
  a_r5_hold_without_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !done_q[hidx]) |=> $stable(head_q));
  a_r6_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cm_reg_we, cm_mem_we, cm_flush}));
endmodule

// File: tb/retire_queue_bench.sv
module retire_queue_bench;
  localparam int DEPTH = 16, RW = 5, DW = 32, AW = 4;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, rs_free = 0, cmp_valid = 0, cmp_mispredict = 0;
  logic [1:0] iss_kind = 0;
  logic [RW-1:0] iss_dest = 0, lk_reg = 0;
  logic [AW-1:0] cmp_tag = 0;
  logic [DW-1:0] cmp_value = 0;
  logic iss_accept, cm_reg_we, cm_mem_we, cm_flush, lk_hit, lk_ready, full, empty;
  logic [AW-1:0] iss_tag, lk_tag;
  logic [RW-1:0] cm_dest;
  logic [DW-1:0] cm_value, lk_value;

  retire_queue #(.DEPTH(DEPTH), .RW(RW), .DW(DW)) u_retire_queue (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, flushes = 0;
  bit finished = 0;
  int m_head = 0, m_count = 0;
  bit [1:0] m_kind [DEPTH];
  bit [RW-1:0] m_dest [DEPTH];
  bit [DW-1:0] m_val [DEPTH];
  bit m_done [DEPTH], m_mis [DEPTH];
  int force_mis = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int youngest(bit [RW-1:0] r);
    int y = -1;
    for (int o = 0; o < m_count; o++) begin
      int i = (m_head + o) % DEPTH;
      if (m_kind[i] == 0 && m_dest[i] == r) y = i;
    end
    return y;
  endfunction

  task automatic step(bit iv, bit rsf, bit [1:0] kd, bit [RW-1:0] ds, bit try_cmp, bit [RW-1:0] lr);
    int hi, ctag, y;
    bit fire, exp_flush, exp_acc;
    iss_valid = iv; rs_free = rsf; iss_kind = kd; iss_dest = ds; lk_reg = lr;
    cmp_valid = 0; ctag = -1;
    if (try_cmp && m_count > 0) begin
      int r = $urandom % m_count;
      for (int o = 0; o < m_count; o++) begin
        int i = (m_head + (r + o) % m_count) % DEPTH;
        if (ctag < 0 && !m_done[i]) ctag = i;
      end
    end
    if (ctag >= 0) begin
      cmp_valid = 1; cmp_tag = AW'(ctag); cmp_value = $urandom;
      cmp_mispredict = (force_mis != 0) ? 1'b1 : (($urandom % 8) == 0);
    end
    #1;
    hi = m_head;
    fire = m_count > 0 && m_done[hi];
    exp_flush = fire && m_kind[hi] == 2 && m_mis[hi];
    exp_acc = iv && rsf && m_count < DEPTH && !exp_flush;
    chk("R3 full", full, m_count == DEPTH);
    chk("R3 empty", empty, m_count == 0);
    chk("R2 accept", iss_accept, exp_acc);
    if (exp_acc) chk("R2 tag", iss_tag, (m_head + m_count) % DEPTH);
    chk("R5 R6 reg write", cm_reg_we, fire && m_kind[hi] == 0);
    chk("R6 store", cm_mem_we, fire && m_kind[hi] == 1);
    chk("R7 flush", cm_flush, exp_flush);
    if (fire && m_kind[hi] != 2) begin
      chk("R6 dest", cm_dest, m_dest[hi]);
      chk("R4 R6 value", cm_value, m_val[hi]);
    end
    y = youngest(lr);
    chk("R8 R10 hit", lk_hit, y >= 0);
    if (y >= 0) begin
      chk("R8 tag", lk_tag, y);
      chk("R9 ready", lk_ready, m_done[y]);
      if (m_done[y]) chk("R9 value", lk_value, m_val[y]);
    end
    @(posedge clk);
    if (exp_flush) begin
      flushes++;
      m_head = (m_head + 1) % DEPTH; m_count = 0;
    end else begin
      if (fire) begin m_head = (m_head + 1) % DEPTH; m_count--; end
      if (ctag >= 0) begin m_done[ctag] = 1; m_val[ctag] = cmp_value; m_mis[ctag] = cmp_mispredict; end
      if (exp_acc) begin
        int t = (hi + m_count + (fire ? 1 : 0)) % DEPTH;
        m_kind[t] = kd; m_dest[t] = ds; m_done[t] = 0; m_mis[t] = 0; m_count++;
      end
    end
    @(negedge clk);
    cmp_valid = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 no retire", {cm_reg_we, cm_mem_we, cm_flush}, 0);
    @(negedge clk);
    // R3: fill without completions, then refused while full
    for (int k = 0; k < DEPTH + 3; k++) step(1, 1, (k % 5 == 4) ? 2'd1 : 2'd0, RW'(k % 4), 0, RW'(k % 4));
    chk("R3 full after fill", full, 1);
    // R2: rs_free low blocks issue
    step(1, 0, 0, 1, 0, 1);
    // R4 R5: out-of-order completions, drain
    for (int k = 0; k < 4 * DEPTH; k++) step(0, 1, 0, 0, ($urandom % 2) == 1, RW'($urandom % 4));
    chk("R5 drained", empty, 1);
    // R7: directed mispredict flush
    force_mis = 1;
    step(1, 1, 2, 0, 0, 0);
    step(1, 1, 0, 3, 0, 3);
    step(1, 1, 0, 3, 0, 3);
    for (int k = 0; k < 8 && m_count > 0; k++) step(0, 1, 0, 0, 1, 3);
    chk("R7 flushed", flushes > 0, 1);
    force_mis = 0;
    // random mix
    for (int k = 0; k < 5000; k++)
      step(($urandom % 4) != 0, ($urandom % 8) != 0, ($urandom % 6 == 0) ? 2'd2 : (($urandom % 5 == 0) ? 2'd1 : 2'd0),
           RW'($urandom % 6), ($urandom % 3) != 0, RW'($urandom % 6));
    chk("R7 random flushes seen", flushes > 1, 1);
    finished = 1;
    summary();
    $finish;
  end
endmodule